// File: doc/BRIEF.md
# Register-Mapped Pin Bank with Atomic Set and Clear

This block is a general-purpose I/O bank placed behind a plain register bus. It has one output latch and one direction state, each one bit per line, plus a two-flop synchronizer on the pad inputs. Software changes single output bits without a read-modify-write. It writes ones to a set register to drive lines high and ones to a clear register to drive them low. The set register also reads back the latch. A line is made an output or an input through either of two direction registers. The two hold one shared state and always read as each other's inverse, so no line can be both input and output at once.

The number of lines equals the register width, which is fixed at elaboration to 8, 16, 32 or 64. Two elaboration switches change how line numbers map onto register bits. One reverses the bit order so that the highest register bit holds line 0. The other presents every register in big-endian byte order. Every pad output and pad enable comes straight from a flop. Read data is registered and is valid in the cycle after the read strobe.

Top module: `pin_bank_ctrl`

## Requirements
- R1: In a cycle where rst is high at the clock edge, all lines become inputs (pad_oe all 0), the output latch and pad_out go to 0, and bus_rdata goes to 0.
- R2: A read strobe at offset 0x00 places in bus_rdata, after that edge, the pad_in level that was sampled two clock edges earlier; 1 means the line is high. After any edge without a read strobe, bus_rdata is 0.
- R3: A write to offset 0x04 sets every latch bit whose written bit is 1 and keeps the other bits. pad_out shows the new latch right after the write edge, whatever the line's direction.
- R4: A write to offset 0x08 clears every latch bit whose written bit is 1 and keeps the other bits.
- R5: A read of offset 0x04 returns the output latch as it was before any write in the same cycle.
- R6: A write to offset 0x0C replaces the direction state, where 1 means output. pad_oe follows the direction state right after the write edge. A read of 0x0C returns the direction state.
- R7: A write to offset 0x10 stores the bitwise inverse of the written value as the direction state, where a written 1 means input. A read of 0x10 returns the inverse of what 0x0C returns.
- R8: With MIRROR set, line n sits at register bit WIDTH-1-n in every register, for both reads and writes.
- R9: With BSWAP set, byte k of the line-ordered value sits at byte WIDTH/8-1-k of the register, for both reads and writes. BSWAP with WIDTH 64, or any WIDTH other than 8, 16, 32 or 64, is rejected at elaboration.
- R10: A read of offset 0x08 or of any offset other than 0x00, 0x04, 0x0C and 0x10 returns 0. A write to 0x00 or to any unlisted offset changes neither pad_out nor pad_oe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | WIDTH | Write data in register bit order |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | WIDTH | Registered read data, valid the cycle after bus_re |
| pad_in | input | WIDTH | Asynchronous pad levels, line order |
| pad_out | output | WIDTH | Pad output values, line order |
| pad_oe | output | WIDTH | Pad output enables, 1 drives the pad |

## Verification
A corrupted latch bit shows on pad_out in the cycle after the edge that corrupted it. It also shows in the next read of the set register. A corrupted direction bit shows at once on pad_oe, and in both direction registers, which must stay exact inverses. A wrong bit or byte mapping shows as a displaced bit on the first write or read that is not symmetric. A synchronizer stage too short or too long shows as a data read that is one cycle early or late after a pad edge. A reference model compares bus_rdata, pad_out and pad_oe on every clock. It does this for a plain, a mirrored and a byte-swapped instance, so any of these faults is caught within the cycle it first reaches a port.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;

  // Register selection decoded from the byte offset.
  typedef enum logic [2:0] {
    SEL_LEVEL  = 3'd0,
    SEL_RAISE  = 3'd1,
    SEL_LOWER  = 3'd2,
    SEL_DRIVE  = 3'd3,
    SEL_SENSE  = 3'd4,
    SEL_NONE   = 3'd5
  } reg_sel_e;

  localparam logic [31:0] OFS_LEVEL = 32'h00;
  localparam logic [31:0] OFS_RAISE = 32'h04;
  localparam logic [31:0] OFS_LOWER = 32'h08;
  localparam logic [31:0] OFS_DRIVE = 32'h0C;
  localparam logic [31:0] OFS_SENSE = 32'h10;

  function automatic reg_sel_e decode_sel(input logic [31:0] ofs);
    reg_sel_e s;
    case (ofs)
      OFS_LEVEL: s = SEL_LEVEL;
      OFS_RAISE: s = SEL_RAISE;
      OFS_LOWER: s = SEL_LOWER;
      OFS_DRIVE: s = SEL_DRIVE;
      OFS_SENSE: s = SEL_SENSE;
      default:   s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/pin_bank_xlate.sv
// Maps between line order and register order. TO_REG=1: line -> register
// (mirror first, then byte swap); TO_REG=0: the exact inverse.
module pin_bank_xlate #(
  parameter int WIDTH  = 32,
  parameter bit MIRROR = 1'b0,
  parameter bit BSWAP  = 1'b0,
  parameter bit TO_REG = 1'b1
) (
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int NBYTE = WIDTH / 8;

  logic [WIDTH-1:0] mir_in, mir_out, sw_in, sw_out;

  generate
    if (TO_REG) begin : g_fwd
      assign mir_in = din;
      assign sw_in  = mir_out;
      assign dout   = sw_out;
    end else begin : g_inv
      assign sw_in  = din;
      assign mir_in = sw_out;
      assign dout   = mir_out;
    end

    if (MIRROR) begin : g_mir
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign mir_out[i] = mir_in[WIDTH-1-i];
      end
    end else begin : g_nomir
      assign mir_out = mir_in;
    end

    if (BSWAP) begin : g_sw
      for (genvar b = 0; b < NBYTE; b++) begin : g_byte
        assign sw_out[8*b +: 8] = sw_in[8*(NBYTE-1-b) +: 8];
      end
    end else begin : g_nosw
      assign sw_out = sw_in;
    end
  endgenerate

endmodule

// File: rtl/pin_bank_sync.sv
// Two-stage synchronizer for the pad inputs.
module pin_bank_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1   <= '0;
      sync_out <= '0;
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end

endmodule

// File: rtl/pin_bank_state.sv
// Output latch and shared direction state, all in line order.
module pin_bank_state #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_raise,
  input  logic             wr_lower,
  input  logic             wr_drive,
  input  logic             wr_sense,
  input  logic [WIDTH-1:0] wline,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] dir_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else begin
      if (wr_raise) latch_q <= latch_q | wline;
      if (wr_lower) latch_q <= latch_q & ~wline;
      if (wr_drive) dir_q   <= wline;
      if (wr_sense) dir_q   <= ~wline;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_raise, wr_lower, wr_drive, wr_sense})); // R3
  AST_RAISE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    wr_raise |=> ((latch_q & $past(latch_q)) == $past(latch_q))); // R3
  AST_LOWER_KEEPS: assert property (@(posedge clk) disable iff (rst)
    wr_lower |=> ((latch_q & ~$past(latch_q)) == '0)); // R4
  AST_LATCH_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(wr_raise || wr_lower) |=> $stable(latch_q)); // R3
  AST_DIR_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(wr_drive || wr_sense) |=> $stable(dir_q)); // R6

endmodule

// File: rtl/pin_bank_ctrl.sv
module pin_bank_ctrl
  import pin_bank_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 5,
  parameter bit MIRROR = 1'b0,
  parameter bit BSWAP  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe
);

  // Elaboration checks on the configuration.
  generate
    if (!(WIDTH == 8 || WIDTH == 16 || WIDTH == 32 || WIDTH == 64)) begin : g_bad_width
      $error("pin_bank_ctrl: WIDTH must be 8, 16, 32 or 64");
    end
    if (BSWAP && WIDTH == 64) begin : g_bad_swap
      $error("pin_bank_ctrl: byte swapping is not available at 64 bits");
    end
    if (ADDR_W < 5 || ADDR_W > 32) begin : g_bad_addr
      $error("pin_bank_ctrl: ADDR_W must be 5 to 32");
    end
  endgenerate

  reg_sel_e         sel;
  logic [WIDTH-1:0] wline;
  logic [WIDTH-1:0] level_line;
  logic [WIDTH-1:0] latch_q, dir_q;
  logic [WIDTH-1:0] rd_line, rd_reg;

  assign sel = decode_sel(32'(bus_addr));

  // Write path: register order -> line order.
  pin_bank_xlate #(
    .WIDTH(WIDTH), .MIRROR(MIRROR), .BSWAP(BSWAP), .TO_REG(1'b0)
  ) u_wr_map (
    .din(bus_wdata), .dout(wline)
  );

  pin_bank_sync #(.WIDTH(WIDTH)) u_sync (
    .clk(clk), .rst(rst), .async_in(pad_in), .sync_out(level_line)
  );

  pin_bank_state #(.WIDTH(WIDTH)) u_state (
    .clk      (clk),
    .rst      (rst),
    .wr_raise (bus_we && sel == SEL_RAISE),
    .wr_lower (bus_we && sel == SEL_LOWER),
    .wr_drive (bus_we && sel == SEL_DRIVE),
    .wr_sense (bus_we && sel == SEL_SENSE),
    .wline    (wline),
    .latch_q  (latch_q),
    .dir_q    (dir_q)
  );

  // Read selection in line order, then one translation to register order.
  always_comb begin
    case (sel)
      SEL_LEVEL: rd_line = level_line;
      SEL_RAISE: rd_line = latch_q;
      SEL_DRIVE: rd_line = dir_q;
      SEL_SENSE: rd_line = ~dir_q;
      default:   rd_line = '0;
    endcase
  end

  pin_bank_xlate #(
    .WIDTH(WIDTH), .MIRROR(MIRROR), .BSWAP(BSWAP), .TO_REG(1'b1)
  ) u_rd_map (
    .din(rd_line), .dout(rd_reg)
  );

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_reg;
    else             bus_rdata <= '0;
  end

  assign pad_out = latch_q;
  assign pad_oe  = dir_q;

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> (bus_rdata == '0)); // R2
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_re && (sel == SEL_NONE || sel == SEL_LOWER)) |=> (bus_rdata == '0)); // R10
  AST_INERT_WRITE: assert property (@(posedge clk) disable iff (rst)
    (bus_we && (sel == SEL_NONE || sel == SEL_LEVEL)) |=> ($stable(pad_out) && $stable(pad_oe))); // R10

endmodule

// File: tb/sim_pin_bank_ctrl.sv
module sim_pin_bank_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] pad = '0;
  logic        we = 1'b0;
  logic        re = 1'b0;

  logic [31:0] rd0, po0, oe0;
  logic [15:0] rd1, po1, oe1;
  logic [31:0] rd2, po2, oe2;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_bank_ctrl #(.WIDTH(32), .MIRROR(1'b0), .BSWAP(1'b0)) u0 (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wdata(wdata[31:0]), .bus_we(we),
    .bus_re(re), .bus_rdata(rd0), .pad_in(pad[31:0]), .pad_out(po0), .pad_oe(oe0));
  pin_bank_ctrl #(.WIDTH(16), .MIRROR(1'b1), .BSWAP(1'b0)) u1 (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wdata(wdata[15:0]), .bus_we(we),
    .bus_re(re), .bus_rdata(rd1), .pad_in(pad[15:0]), .pad_out(po1), .pad_oe(oe1));
  pin_bank_ctrl #(.WIDTH(32), .MIRROR(1'b0), .BSWAP(1'b1)) u2 (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wdata(wdata[31:0]), .bus_we(we),
    .bus_re(re), .bus_rdata(rd2), .pad_in(pad[31:0]), .pad_out(po2), .pad_oe(oe2));

  // ---------------- reference model ----------------
  int          wid [3] = '{32, 16, 32};
  bit          mirr[3] = '{1'b0, 1'b1, 1'b0};
  bit          swp [3] = '{1'b0, 1'b0, 1'b1};
  logic [63:0] m_lat[3], m_dir[3], m_rd[3];
  int          m_rtag[3];
  logic [63:0] m_hist[3][$];

  function automatic logic [63:0] msk(input int w);
    return (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
  endfunction
  function automatic logic [63:0] mir(input logic [63:0] v, input int w);
    logic [63:0] r = '0;
    for (int i = 0; i < w; i++) r[i] = v[w-1-i];
    return r;
  endfunction
  function automatic logic [63:0] bsw(input logic [63:0] v, input int w);
    logic [63:0] r = '0;
    for (int b = 0; b < w/8; b++) r[8*b +: 8] = v[8*(w/8-1-b) +: 8];
    return r;
  endfunction
  function automatic logic [63:0] l2r(input logic [63:0] v, input int k);
    logic [63:0] t = mirr[k] ? mir(v, wid[k]) : v;
    return swp[k] ? bsw(t, wid[k]) : t;
  endfunction
  function automatic logic [63:0] r2l(input logic [63:0] v, input int k);
    logic [63:0] t = swp[k] ? bsw(v, wid[k]) : v;
    return mirr[k] ? mir(t, wid[k]) : t;
  endfunction

  initial begin
    for (int k = 0; k < 3; k++) begin
      m_lat[k] = '0; m_dir[k] = '0; m_rd[k] = '0; m_rtag[k] = 0;
      m_hist[k] = '{64'd0, 64'd0};
    end
  end

  always @(posedge clk) begin
    for (int k = 0; k < 3; k++) begin
      logic [63:0] lv, wl, mk;
      mk = msk(wid[k]);
      if (rst) begin
        m_lat[k] = '0; m_dir[k] = '0; m_rd[k] = '0;
        m_hist[k] = '{64'd0, 64'd0};
      end else begin
        case (addr)
          5'h00:   lv = m_hist[k][0];
          5'h04:   lv = m_lat[k];
          5'h0C:   lv = m_dir[k];
          5'h10:   lv = ~m_dir[k] & mk;
          default: lv = '0;
        endcase
        m_rd[k] = re ? l2r(lv, k) : '0;
        m_rtag[k] = int'(addr);
        wl = r2l(wdata & mk, k);
        if (we) begin
          case (addr)
            5'h04: m_lat[k] = m_lat[k] | wl;
            5'h08: m_lat[k] = m_lat[k] & ~wl;
            5'h0C: m_dir[k] = wl;
            5'h10: m_dir[k] = ~wl & mk;
            default: ;
          endcase
        end
        void'(m_hist[k].pop_front());
        m_hist[k].push_back(pad & mk);
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string rtag(input int k);
    if (k == 1) return "R8 read";
    if (k == 2) return "R9 read";
    case (m_rtag[k])
      'h00: return "R2 data read";
      'h04: return "R5 latch read";
      'h0C, 'h10: return "R7 direction read";
      default: return "R10 unmapped read";
    endcase
  endfunction

  task automatic compare_all();
    chk(rtag(0), 64'(rd0), m_rd[0]);
    chk("R3 pad_out", 64'(po0), m_lat[0]);
    chk("R6 pad_oe", 64'(oe0), m_dir[0]);
    chk(rtag(1), 64'(rd1), m_rd[1]);
    chk("R8 pad_out", 64'(po1), m_lat[1]);
    chk("R8 pad_oe", 64'(oe1), m_dir[1]);
    chk(rtag(2), 64'(rd2), m_rd[2]);
    chk("R9 pad_out", 64'(po2), m_lat[2]);
    chk("R9 pad_oe", 64'(oe2), m_dir[2]);
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(input logic [4:0] a, input logic [63:0] d);
    addr = a; wdata = d; we = 1'b1; re = 1'b0;
    cyc();
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a);
    addr = a; re = 1'b1; we = 1'b0;
    cyc();
    re = 1'b0;
  endtask

  initial begin
    pad = 64'hFFFF_FFFF_FFFF_FFFF;
    we = 1'b1; re = 1'b1; addr = 5'h04; wdata = '1;
    repeat (3) cyc();
    we = 1'b0; re = 1'b0;
    // R1: reset state
    chk("R1 pad_oe", 64'(oe0), 64'd0);
    chk("R1 pad_out", 64'(po0), 64'd0);
    chk("R1 rdata", 64'(rd0), 64'd0);
    rst = 1'b0;
    cyc();

    // R6 / R7: direction registers
    wr(5'h0C, 64'h0000_FFFF);
    chk("R6 pad_oe after write", 64'(oe0), 64'h0000_FFFF);
    rd(5'h0C);
    rd(5'h10);
    chk("R7 inverse read", 64'(rd0), 64'hFFFF_0000);

    // R3 / R4 / R5: set and clear
    wr(5'h04, 64'hA5A5_00F0);
    chk("R3 set", 64'(po0), 64'hA5A5_00F0);
    chk("R8 mirrored set", 64'(po1), 64'h0000_0F00);
    chk("R9 swapped set", 64'(po2), 64'hF000_A5A5);
    rd(5'h04);
    wr(5'h08, 64'h0000_0030);
    chk("R4 clear", 64'(po0), 64'hA5A5_00C0);
    chk("R9 swapped clear", 64'(po2), 64'hC000_A5A5);
    wr(5'h04, 64'h0);
    chk("R3 zero set keeps", 64'(po0), 64'hA5A5_00C0);
    rd(5'h04);
    chk("R5 latch read", 64'(rd0), 64'hA5A5_00C0);
    wr(5'h10, 64'h00FF_00FF);
    chk("R7 input-direction write", 64'(oe0), 64'hFF00_FF00);
    rd(5'h0C);

    // R2: data read and synchronizer latency
    pad = 64'h1234_5678_9ABC_DEF0;
    rd(5'h00); rd(5'h00); rd(5'h00);
    pad = 64'h0F0F_0F0F_F0F0_F0F0;
    rd(5'h00); rd(5'h00);
    pad = 64'h0;
    cyc(); cyc();
    rd(5'h00);
    chk("R2 data after settle", 64'(rd0), 64'h0);

    // R10: inert writes and empty reads
    wr(5'h00, 64'hFFFF_FFFF);
    chk("R10 data write inert", 64'(po0), 64'hA5A5_00C0);
    wr(5'h14, 64'hFFFF_FFFF);
    wr(5'h06, 64'hFFFF_FFFF);
    chk("R10 unmapped write inert", 64'(oe0), 64'hFF00_FF00);
    rd(5'h08); rd(5'h14); rd(5'h1C); rd(5'h02);

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [4:0] alist [7] = '{5'h00, 5'h04, 5'h08, 5'h0C, 5'h10, 5'h14, 5'h01};
      addr  = alist[$urandom_range(0, 6)];
      wdata = {$urandom, $urandom};
      we    = 1'($urandom_range(0, 1));
      re    = 1'($urandom_range(0, 1));
      if ((i % 3) == 0) pad = {$urandom, $urandom};
      cyc();
    end
    we = 1'b0; re = 1'b0;
    cyc();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule